// File: doc/BRIEF.md
# Triple-Sensor Median Voter with Temperature Trip

This block accepts three raw signed 16-bit readings from redundant temperature sensors, presented together with a one-cycle sample strobe. Each reading is converted to unsigned fixed-point tenths of a degree and checked for plausibility. The healthy readings are then voted into one temperature.

With three healthy channels the vote is their median. With two, the vote is the lower reading by default, and a parameter can select the higher one instead. With fewer than two, the output is declared invalid and forced to zero. A high-temperature trip is raised only when the vote is valid and at or above the set point. All outputs are registered. They change two cycles after the strobe, together with an output strobe, and they hold their values between strobes.

Top module: `tmv_top`

## Requirements
- R1: For a healthy channel, the scaled value is floor(raw * 5000 / 27648) in tenths of a degree. Raw 0 gives 0, raw 27648 gives 5000 (500.0 degrees), and raw 19354 gives 3500.
- R2: Bit i of o_fault is set for channel i (i_raw0 is bit 0, i_raw2 is bit 2) when its raw value is negative, which means the scaled value is below 0. The bit is also set when the scaled value exceeds 6000 (600.0 degrees).
- R3: With no channel faulted, o_temp is the median of the three scaled values and o_valid is 1.
- R4: With exactly one channel faulted, o_valid is 1 and o_temp is the lower of the two healthy scaled values (default pair mode).
- R5: With two or three channels faulted, o_valid is 0 and o_temp is 0.
- R6: o_trip is 1 exactly when o_valid is 1 and o_temp is at least 3500.
- R7: A sample strobed on i_stb produces o_stb high for one cycle two clock cycles later, with the results of that sample on o_temp, o_valid, o_fault and o_trip. Without a strobe, the outputs hold their values and changes on the raw inputs have no effect.
- R8: While the synchronous reset is high, o_stb, o_valid, o_temp, o_fault and o_trip are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| i_stb | input | 1 | Sample strobe; the raw inputs are taken when it is high |
| i_raw0 | input | 16 | Raw signed reading, channel 0 |
| i_raw1 | input | 16 | Raw signed reading, channel 1 |
| i_raw2 | input | 16 | Raw signed reading, channel 2 |
| o_stb | output | 1 | One-cycle pulse marking new results |
| o_valid | output | 1 | Vote is valid (at least two healthy channels) |
| o_temp | output | 16 | Voted temperature in tenths of a degree |
| o_fault | output | 3 | Per-channel fault flags |
| o_trip | output | 1 | High-temperature trip |

## Verification
Random triples of in-range readings exercise the median path. The position of the middle value varies, so a voter that always picks a fixed channel or the minimum would be caught. Random negative readings produce one, two or three faulted channels. These separate the lower-of-pair rule from the median rule, and show that the zero-and-invalid fallback is applied. Directed samples check the scaling end points and readings just below and at the 3500 set point, with ties among channels. Junk on the raw inputs between strobes checks that the outputs hold.

// File: rtl/tmv_pkg.sv
package tmv_pkg;
    localparam int NCH = 3;

    typedef enum logic {
        PAIR_LOW  = 1'b0,
        PAIR_HIGH = 1'b1
    } pair_sel_e;
endpackage

// File: rtl/tmv_scale.sv
// One channel: raw count to tenths of a degree with a reciprocal multiply,
// plausibility check, registered on the sample strobe.
module tmv_scale #(
    parameter int RAW_W       = 16,
    parameter int TEMP_W      = 16,
    parameter int FULL_RAW    = 27648,
    parameter int FULL_TENTHS = 5000,
    parameter int FAULT_HI    = 6000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    i_stb,
    input  logic signed [RAW_W-1:0] i_raw,
    output logic [TEMP_W-1:0]       o_val,
    output logic                    o_fault
);
    localparam int XMAX_BITS = $clog2((2**(RAW_W-1) - 1) * FULL_TENTHS);
    localparam int SHIFT     = XMAX_BITS + $clog2(FULL_RAW) + 1;
    localparam logic [63:0] RECIP =
        ((64'd1 << SHIFT) + 64'(FULL_RAW) - 64'd1) / 64'(FULL_RAW);

    typedef struct packed {
        logic [TEMP_W-1:0] val;
        logic              fault;
    } chan_t;

    chan_t ch_d, ch_q;
    logic [63:0] prod, quot;
    logic        neg, over;

    always_comb begin
        prod = 64'(i_raw[RAW_W-2:0]) * 64'(FULL_TENTHS);
        quot = (prod * RECIP) >> SHIFT;
        neg  = i_raw[RAW_W-1];
        over = quot > 64'(FAULT_HI);
        ch_d = ch_q;
        if (i_stb) begin
            ch_d.val   = neg ? '0 : TEMP_W'(quot);
            ch_d.fault = neg | over;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ch_q <= '0;
        else     ch_q <= ch_d;
    end

    assign o_val   = ch_q.val;
    assign o_fault = ch_q.fault;

    AST_NEG_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (i_stb && i_raw[RAW_W-1]) |=> o_fault); // R2

    AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (rst)
        !$past(i_stb) |-> $stable(ch_q)); // R7
endmodule

// File: rtl/tmv_vote.sv
// Combinational voter: median of three, chosen one of two, or invalid.
module tmv_vote
    import tmv_pkg::*;
#(
    parameter int        TEMP_W    = 16,
    parameter pair_sel_e PAIR_MODE = PAIR_LOW
) (
    input  logic [NCH-1:0][TEMP_W-1:0] i_val,
    input  logic [NCH-1:0]             i_fault,
    output logic [TEMP_W-1:0]          o_temp,
    output logic                       o_valid
);
    logic [TEMP_W-1:0] a, b, c, lo_ab, hi_ab, mid_hc, med;
    logic [TEMP_W-1:0] p0, p1, pair_lo, pair_hi, pair_out;
    logic [1:0]        n_ok;

    always_comb begin
        a      = i_val[0];
        b      = i_val[1];
        c      = i_val[2];
        lo_ab  = (a < b) ? a : b;
        hi_ab  = (a < b) ? b : a;
        mid_hc = (hi_ab < c) ? hi_ab : c;
        med    = (mid_hc > lo_ab) ? mid_hc : lo_ab;
        unique case (i_fault)
            3'b001:  begin p0 = b; p1 = c; end
            3'b010:  begin p0 = a; p1 = c; end
            3'b100:  begin p0 = a; p1 = b; end
            default: begin p0 = '0; p1 = '0; end
        endcase
        pair_lo = (p0 < p1) ? p0 : p1;
        pair_hi = (p0 < p1) ? p1 : p0;
        n_ok    = 2'($countones(~i_fault));
    end

    generate
        if (PAIR_MODE == PAIR_HIGH) begin : g_pair_high
            assign pair_out = pair_hi;
        end else begin : g_pair_low
            assign pair_out = pair_lo;
        end
    endgenerate

    always_comb begin
        o_valid = (n_ok >= 2'd2);
        if (n_ok == 2'd3)      o_temp = med;
        else if (n_ok == 2'd2) o_temp = pair_out;
        else                   o_temp = '0;
    end
endmodule

// File: rtl/tmv_top.sv
module tmv_top
    import tmv_pkg::*;
#(
    parameter int        RAW_W       = 16,
    parameter int        TEMP_W      = 16,
    parameter int        FULL_RAW    = 27648,
    parameter int        FULL_TENTHS = 5000,
    parameter int        FAULT_HI    = 6000,
    parameter int        TRIP_AT     = 3500,
    parameter pair_sel_e PAIR_MODE   = PAIR_LOW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    i_stb,
    input  logic signed [RAW_W-1:0] i_raw0,
    input  logic signed [RAW_W-1:0] i_raw1,
    input  logic signed [RAW_W-1:0] i_raw2,
    output logic                    o_stb,
    output logic                    o_valid,
    output logic [TEMP_W-1:0]       o_temp,
    output logic [NCH-1:0]          o_fault,
    output logic                    o_trip
);
    typedef struct packed {
        logic              st1;
        logic              stb;
        logic              valid;
        logic [TEMP_W-1:0] temp;
        logic [NCH-1:0]    fault;
        logic              trip;
    } state_t;

    logic [NCH-1:0][RAW_W-1:0]  raw_arr;
    logic [NCH-1:0][TEMP_W-1:0] ch_val;
    logic [NCH-1:0]             ch_fault;
    logic [TEMP_W-1:0]          v_temp;
    logic                       v_valid;
    state_t                     s_d, s_q;

    assign raw_arr = {i_raw2, i_raw1, i_raw0};

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chan
            tmv_scale #(
                .RAW_W      (RAW_W),
                .TEMP_W     (TEMP_W),
                .FULL_RAW   (FULL_RAW),
                .FULL_TENTHS(FULL_TENTHS),
                .FAULT_HI   (FAULT_HI)
            ) u_scale (
                .clk    (clk),
                .rst    (rst),
                .i_stb  (i_stb),
                .i_raw  (raw_arr[g]),
                .o_val  (ch_val[g]),
                .o_fault(ch_fault[g])
            );
        end
    endgenerate

    tmv_vote #(
        .TEMP_W   (TEMP_W),
        .PAIR_MODE(PAIR_MODE)
    ) u_vote (
        .i_val  (ch_val),
        .i_fault(ch_fault),
        .o_temp (v_temp),
        .o_valid(v_valid)
    );

    always_comb begin
        s_d     = s_q;
        s_d.st1 = i_stb;
        s_d.stb = 1'b0;
        if (s_q.st1) begin
            s_d.stb   = 1'b1;
            s_d.valid = v_valid;
            s_d.temp  = v_temp;
            s_d.fault = ch_fault;
            s_d.trip  = v_valid && (v_temp >= TEMP_W'(TRIP_AT));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign o_stb   = s_q.stb;
    assign o_valid = s_q.valid;
    assign o_temp  = s_q.temp;
    assign o_fault = s_q.fault;
    assign o_trip  = s_q.trip;

    AST_TRIP_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        o_trip |-> (o_valid && o_temp >= TEMP_W'(TRIP_AT))); // R6

    AST_INVALID_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !o_valid |-> (o_temp == '0)); // R5

    AST_VALID_MATCHES_FAULTS: assert property (@(posedge clk) disable iff (rst)
        o_stb |-> (o_valid == ($countones(~o_fault) >= 2))); // R5

    AST_STB_LATENCY: assert property (@(posedge clk) disable iff (rst)
        o_stb == ($past(i_stb, 2) && !$past(rst) && !$past(rst, 2))); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !o_stb |-> ($stable(o_temp) && $stable(o_fault) && $stable(o_valid))); // R7
endmodule

// File: tb/tmv_top_bench.sv
module tmv_top_bench;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               i_stb = 1'b0;
    logic signed [15:0] i_raw0 = '0, i_raw1 = '0, i_raw2 = '0;
    logic               o_stb, o_valid, o_trip;
    logic [15:0]        o_temp;
    logic [2:0]         o_fault;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmv_top u_tmv_top (
        .clk    (clk),
        .rst    (rst),
        .i_stb  (i_stb),
        .i_raw0 (i_raw0),
        .i_raw1 (i_raw1),
        .i_raw2 (i_raw2),
        .o_stb  (o_stb),
        .o_valid(o_valid),
        .o_temp (o_temp),
        .o_fault(o_fault),
        .o_trip (o_trip)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int scl(input int raw);
        return (raw < 0) ? 0 : (raw * 5000) / 27648;
    endfunction

    function automatic bit flt(input int raw);
        return (raw < 0) || (scl(raw) > 6000);
    endfunction

    task automatic send(input int r0, input int r1, input int r2, input bit hold_chk);
        int rv[3];
        int ok_v[3];
        int n;
        int e_temp;
        int t;
        bit e_valid;
        bit e_trip;
        logic [2:0] e_fault;
        rv[0] = r0; rv[1] = r1; rv[2] = r2;
        n = 0;
        for (int i = 0; i < 3; i++) begin
            e_fault[i] = flt(rv[i]);
            if (!e_fault[i]) begin ok_v[n] = scl(rv[i]); n++; end
        end
        if (n == 3) begin
            for (int i = 0; i < 2; i++)
                for (int j = 0; j < 2 - i; j++)
                    if (ok_v[j] > ok_v[j+1]) begin
                        t = ok_v[j]; ok_v[j] = ok_v[j+1]; ok_v[j+1] = t;
                    end
            e_temp = ok_v[1];
        end else if (n == 2) begin
            e_temp = (ok_v[0] < ok_v[1]) ? ok_v[0] : ok_v[1];
        end else begin
            e_temp = 0;
        end
        e_valid = (n >= 2);
        e_trip  = e_valid && (e_temp >= 3500);

        @(negedge clk);
        i_raw0 = 16'(r0); i_raw1 = 16'(r1); i_raw2 = 16'(r2);
        i_stb  = 1'b1;
        @(negedge clk);
        i_stb  = 1'b0;
        i_raw0 = 16'($urandom); i_raw1 = 16'($urandom); i_raw2 = 16'($urandom);
        @(negedge clk);
        chk(o_stb == 1'b1, "R7 strobe latency", int'(o_stb), 1);
        chk(o_fault == e_fault, "R2 fault flags", int'(o_fault), int'(e_fault));
        chk(o_valid == e_valid, (n == 3) ? "R3 valid" : (n == 2) ? "R4 valid" : "R5 valid",
            int'(o_valid), int'(e_valid));
        chk(int'(o_temp) == e_temp, (n == 3) ? "R3 median" : (n == 2) ? "R4 pair low" : "R5 zero",
            int'(o_temp), e_temp);
        chk(o_trip == e_trip, "R6 trip", int'(o_trip), int'(e_trip));
        if (hold_chk) begin
            i_raw0 = 16'($urandom); i_raw1 = 16'($urandom); i_raw2 = 16'($urandom);
            @(negedge clk);
            chk(o_stb == 1'b0, "R7 strobe single cycle", int'(o_stb), 0);
            chk(int'(o_temp) == e_temp, "R7 hold temp", int'(o_temp), e_temp);
            chk(o_fault == e_fault, "R7 hold fault", int'(o_fault), int'(e_fault));
        end
    endtask

    function automatic int rnd_raw();
        int k;
        k = int'($urandom_range(0, 9));
        if (k < 2)      return -int'($urandom_range(1, 32768));
        else if (k < 4) return int'($urandom_range(19000, 20000));
        else            return int'($urandom_range(0, 32767));
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(o_stb == 1'b0,   "R8 reset o_stb",   int'(o_stb), 0);
        chk(o_valid == 1'b0, "R8 reset o_valid", int'(o_valid), 0);
        chk(o_trip == 1'b0,  "R8 reset o_trip",  int'(o_trip), 0);
        chk(o_temp == '0,    "R8 reset o_temp",  int'(o_temp), 0);
        chk(o_fault == '0,   "R8 reset o_fault", int'(o_fault), 0);
        rst = 1'b0;
        @(negedge clk);

        // R1: scaling end points and set point
        send(27648, 27648, 27648, 1'b1);
        chk(int'(o_temp) == 5000, "R1 full scale", int'(o_temp), 5000);
        send(0, 0, 0, 1'b0);
        chk(int'(o_temp) == 0 && o_valid, "R1 zero scale", int'(o_temp), 0);
        send(19354, 19354, 19354, 1'b0);
        chk(int'(o_temp) == 3500, "R1 set point", int'(o_temp), 3500);
        chk(o_trip == 1'b1, "R6 trip at set point", int'(o_trip), 1);
        send(19353, 19353, 30000, 1'b0);
        chk(o_trip == 1'b0, "R6 no trip just below", int'(o_trip), 0);
        // median position and ties
        send(30000, 100, 15000, 1'b1);
        send(100, 15000, 30000, 1'b0);
        send(15000, 30000, 100, 1'b0);
        send(5000, 5000, 32767, 1'b0);
        // one faulted channel, each position
        send(-1, 30000, 20000, 1'b0);
        send(30000, -32768, 20000, 1'b0);
        send(30000, 20000, -5, 1'b1);
        // R5: two and three faulted, with high reading present
        send(-1, -2, 32767, 1'b1);
        chk(o_trip == 1'b0, "R5 invalid suppresses trip", int'(o_trip), 0);
        send(-7, -8, -9, 1'b0);

        for (int v = 0; v < 300; v++)
            send(rnd_raw(), rnd_raw(), rnd_raw(), (v % 7) == 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R7 watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule